// File: doc/BRIEF.md
# Alarm, Timer and Interrupt Controller

This block sits beside the time-of-day counters of a real-time clock. It watches the hundredths, seconds, minutes, hours, date and month counters and compares them with a bank of alarm registers. It runs a two-digit BCD timer that steps on a chosen time unit. It keeps the two status flags, one for the timer and one for the alarm, and drives an active-low interrupt line meant for an open-drain pad.

Three clock alarm modes are offered. A dated alarm matches the full time and the calendar date. A daily alarm matches the time only. A weekday alarm matches the time on the weekdays picked by a seven-bit mask. When the master alarm enable is low, both flags stop being sticky. The timer flag then follows a seconds square wave and the alarm flag follows a minutes square wave, so the interrupt line carries a 1 Hz calibration signal. In that state the alarm control byte is ignored.

All interfaces are plain level or pulse pins with no handshake. Tick inputs are single-cycle pulses from the counter chain. Clear inputs are single-cycle pulses from the host register write.

Top module: `atc_top`

## Requirements
- R1: After reset, `tflag` and `aflag` are 0, `timer_val` is 8'h00 and `int_n` is 1.
- R2: With `alarm_en`=1, `timer_val` advances by one BCD count on the edge where the tick selected by `acr[2:0]` is high. The codes are 1 hundredths, 2 seconds, 3 minutes, 4 hours and 5 days; codes 0, 6 and 7 stop the timer. Ticks of other units leave it unchanged.
- R3: On a selected tick while `timer_val` is 8'h99, the timer returns to 8'h00 and `tflag` is set on that same edge.
- R4: While `alarm_en`=1, a set flag stays set until its clear pulse. If a clear pulse and a set event arrive in the same cycle, the flag ends up set.
- R5: Dated alarm (`acr[5:4]`=2'b11): `aflag` is set when hundredths, seconds, minutes and hours match exactly, `cnt_ydate[5:0]` matches, and `cnt_wdmon[4:0]` matches. The year bits `[7:6]` and weekday bits `[7:5]` are ignored.
- R6: Daily alarm (`acr[5:4]`=2'b01): a match of hundredths, seconds, minutes and hours alone sets `aflag`, whatever the date and month.
- R7: Weekday alarm (`acr[5:4]`=2'b10): the time match sets `aflag` only if bit `cnt_wdmon[7:5]` of `al_wdmon` is 1.
- R8: A clock or timer alarm sets `aflag` once per match, in the first cycle of the match. Clearing `aflag` while the match persists leaves it at 0.
- R9: With `acr[6]`=1, `aflag` is set one cycle after `timer_val` first equals `al_timer`.
- R10: With `alarm_en`=1, `int_n` is 0 exactly when (`aflag` and `acr[7]`) or (`tflag` and `acr[3]`).
- R11: With `alarm_en`=0, the following hold one cycle after the inputs change. `tflag` is 1 exactly when `cnt_hund` ≥ 8'h50, and `aflag` is 1 exactly when `cnt_sec` ≥ 8'h30. `int_n` is the inverse of `tflag`, and `acr` has no effect. The timer does not advance.
- R12: A `tmr_load` pulse writes `tmr_load_val` into `timer_val` on the next edge, taking precedence over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_en | input | 1 | Master alarm enable from the control byte |
| acr | input | 8 | Alarm control byte: unit[2:0], timer irq en[3], mode[5:4], timer alarm en[6], alarm irq en[7] |
| cnt_hund | input | 8 | Hundredths counter, BCD |
| cnt_sec | input | 8 | Seconds counter, BCD |
| cnt_min | input | 8 | Minutes counter, BCD |
| cnt_hour | input | 8 | Hours counter with format bits |
| cnt_ydate | input | 8 | Year[7:6] and date[5:0] |
| cnt_wdmon | input | 8 | Weekday[7:5] and month[4:0] |
| al_hund | input | 8 | Alarm hundredths |
| al_sec | input | 8 | Alarm seconds |
| al_min | input | 8 | Alarm minutes |
| al_hour | input | 8 | Alarm hours |
| al_ydate | input | 8 | Alarm date |
| al_wdmon | input | 8 | Alarm month, or weekday mask in weekday mode |
| al_timer | input | 8 | Timer alarm value |
| tick_hund | input | 1 | Hundredths tick pulse |
| tick_sec | input | 1 | Seconds tick pulse |
| tick_min | input | 1 | Minutes tick pulse |
| tick_hour | input | 1 | Hours tick pulse |
| tick_day | input | 1 | Days tick pulse |
| tmr_load | input | 1 | Host write of the timer |
| tmr_load_val | input | 8 | Value written to the timer |
| clr_tflag | input | 1 | Host clear of the timer flag |
| clr_aflag | input | 1 | Host clear of the alarm flag |
| tflag | output | 1 | Timer flag, or seconds square wave |
| aflag | output | 1 | Alarm flag, or minutes square wave |
| timer_val | output | 8 | Current timer value, BCD |
| int_n | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach from the ports is a match that already holds when the flag is cleared. The bench must show that the flag stays low. It also must show that the alarm fires again once the counters leave the match and come back. To get there, the stimulus first parks the hundredths counter one count short of the alarm value. It then steps onto the match, issues the clear while the match still holds, and moves off and back on. The timer alarm gets the same treatment: the stimulus loads the timer just below `al_timer` and ticks once, which gives a clean first-match edge.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] hund;
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] ydate;
    logic [BYTE_W-1:0] wdmon;
  } time_set_t;

  typedef enum logic [1:0] {
    AM_NONE    = 2'b00,
    AM_DAILY   = 2'b01,
    AM_WEEKDAY = 2'b10,
    AM_DATED   = 2'b11
  } alarm_mode_e;

  function automatic logic [BYTE_W-1:0] bcd_step(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/atc_clock_match.sv
module atc_clock_match
  import atc_pkg::*;
#(
  parameter int DATE_BITS = 6,
  parameter int MON_BITS  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  time_set_t   cnt,
  input  time_set_t   alm,
  input  alarm_mode_e mode,
  output logic        hit
);
  localparam int WD_LSB = MON_BITS;

  logic       time_eq, date_eq, wd_ok, match, match_q;
  logic [2:0] wday;

  assign wday    = cnt.wdmon[BYTE_W-1:WD_LSB];
  assign time_eq = (cnt.hund == alm.hund) && (cnt.sec == alm.sec) &&
                   (cnt.min == alm.min) && (cnt.hour == alm.hour);
  assign date_eq = (cnt.ydate[DATE_BITS-1:0] == alm.ydate[DATE_BITS-1:0]) &&
                   (cnt.wdmon[MON_BITS-1:0] == alm.wdmon[MON_BITS-1:0]);
  assign wd_ok   = (wday != 3'd7) && alm.wdmon[wday];

  always_comb begin
    unique case (mode)
      AM_DAILY:   match = time_eq;
      AM_WEEKDAY: match = time_eq && wd_ok;
      AM_DATED:   match = time_eq && date_eq;
      default:    match = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;

  assign hit = match && !match_q;
endmodule

// File: rtl/atc_timer.sv
module atc_timer
  import atc_pkg::*;
#(
  parameter int                UNITS = 5,
  parameter logic [BYTE_W-1:0] TOP   = 8'h99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [2:0]        unit_sel,
  input  logic [UNITS-1:0]  ticks,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              alm_on,
  input  logic [BYTE_W-1:0] alm_val,
  output logic [BYTE_W-1:0] value,
  output logic              wrap,
  output logic              alm_hit
);
  localparam int SEL_N = 8;

  logic [SEL_N-1:0] tick_vec;
  logic             step, match, match_q;

  assign tick_vec = SEL_N'({ticks, 1'b0});
  assign step     = run && tick_vec[unit_sel];
  assign wrap     = step && !load && (value == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (wrap) value <= '0;
    else if (step) value <= bcd_step(value);
  end

  assign match = alm_on && (value == alm_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;

  assign alm_hit = run && match && !match_q;
endmodule

// File: rtl/atc_flag.sv
module atc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sticky,
  input  logic set,
  input  logic clr,
  input  logic wave,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (!sticky) q <= wave;
    else if (set)    q <= 1'b1;
    else if (clr)    q <= 1'b0;
  end
endmodule

// File: rtl/atc_top.sv
module atc_top
  import atc_pkg::*;
#(
  parameter int                N_UNITS   = 5,
  parameter logic [BYTE_W-1:0] TIMER_TOP = 8'h99,
  parameter logic [BYTE_W-1:0] HALF_SEC  = 8'h50,
  parameter logic [BYTE_W-1:0] HALF_MIN  = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_en,
  input  logic [7:0]        acr,
  input  logic [BYTE_W-1:0] cnt_hund,
  input  logic [BYTE_W-1:0] cnt_sec,
  input  logic [BYTE_W-1:0] cnt_min,
  input  logic [BYTE_W-1:0] cnt_hour,
  input  logic [BYTE_W-1:0] cnt_ydate,
  input  logic [BYTE_W-1:0] cnt_wdmon,
  input  logic [BYTE_W-1:0] al_hund,
  input  logic [BYTE_W-1:0] al_sec,
  input  logic [BYTE_W-1:0] al_min,
  input  logic [BYTE_W-1:0] al_hour,
  input  logic [BYTE_W-1:0] al_ydate,
  input  logic [BYTE_W-1:0] al_wdmon,
  input  logic [BYTE_W-1:0] al_timer,
  input  logic              tick_hund,
  input  logic              tick_sec,
  input  logic              tick_min,
  input  logic              tick_hour,
  input  logic              tick_day,
  input  logic              tmr_load,
  input  logic [BYTE_W-1:0] tmr_load_val,
  input  logic              clr_tflag,
  input  logic              clr_aflag,
  output logic              tflag,
  output logic              aflag,
  output logic [BYTE_W-1:0] timer_val,
  output logic              int_n
);
  localparam int FLAG_N = 2;
  localparam int F_TMR  = 0;
  localparam int F_ALM  = 1;

  time_set_t          cnt_s, alm_s;
  alarm_mode_e        mode;
  logic [N_UNITS-1:0] ticks;
  logic               clk_hit, tmr_hit, tmr_wrap;
  logic [FLAG_N-1:0]  f_set, f_clr, f_wave, f_q, f_ien;

  assign cnt_s = '{hund: cnt_hund, sec: cnt_sec, min: cnt_min, hour: cnt_hour,
                   ydate: cnt_ydate, wdmon: cnt_wdmon};
  assign alm_s = '{hund: al_hund, sec: al_sec, min: al_min, hour: al_hour,
                   ydate: al_ydate, wdmon: al_wdmon};
  assign mode  = alarm_mode_e'(acr[5:4]);
  assign ticks = N_UNITS'({tick_day, tick_hour, tick_min, tick_sec, tick_hund});

  atc_clock_match u_match (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_s), .alm(alm_s), .mode(mode), .hit(clk_hit)
  );

  atc_timer #(.UNITS(N_UNITS), .TOP(TIMER_TOP)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(alarm_en), .unit_sel(acr[2:0]), .ticks(ticks),
    .load(tmr_load), .load_val(tmr_load_val), .alm_on(acr[6]), .alm_val(al_timer),
    .value(timer_val), .wrap(tmr_wrap), .alm_hit(tmr_hit)
  );

  assign f_set[F_TMR]  = tmr_wrap;
  assign f_set[F_ALM]  = alarm_en && (clk_hit || tmr_hit);
  assign f_clr         = {clr_aflag, clr_tflag};
  assign f_wave[F_TMR] = cnt_hund >= HALF_SEC;
  assign f_wave[F_ALM] = cnt_sec >= HALF_MIN;
  assign f_ien         = {acr[7], acr[3]};

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    atc_flag u_flag (
      .clk(clk), .rst_n(rst_n), .sticky(alarm_en), .set(f_set[g]),
      .clr(f_clr[g]), .wave(f_wave[g]), .q(f_q[g])
    );
  end

  assign tflag = f_q[F_TMR];
  assign aflag = f_q[F_ALM];
  assign int_n = alarm_en ? !(|(f_q & f_ien)) : !f_q[F_TMR];
endmodule

// File: rtl/atc_chk.sv
module atc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alarm_en,
  input logic [7:0] acr,
  input logic [7:0] cnt_sec,
  input logic       tick_hund,
  input logic       tick_sec,
  input logic       tick_min,
  input logic       tick_hour,
  input logic       tick_day,
  input logic       tmr_load,
  input logic [7:0] tmr_load_val,
  input logic       clr_tflag,
  input logic       tflag,
  input logic       aflag,
  input logic [7:0] timer_val,
  input logic       int_n
);
  logic any_tick;
  assign any_tick = tick_hund | tick_sec | tick_min | tick_hour | tick_day;

  // R2: without a tick or load the timer holds
  a_r2_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_load && !any_tick) |=> $stable(timer_val));

  // R3: the wrap from 99 sets the timer flag
  a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && !tmr_load && timer_val == 8'h99 &&
     ((acr[2:0] == 3'd2 && tick_sec) || (acr[2:0] == 3'd1 && tick_hund)))
    |=> (timer_val == 8'h00 && (tflag || !alarm_en)));

  // R4: a sticky flag survives until cleared
  a_r4_tflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && tflag && !clr_tflag) |=> (!alarm_en || tflag));

  // R10: with both interrupt enables off the line stays high
  a_r10_int_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && !acr[7] && !acr[3]) |-> int_n);

  // R11: minutes square wave when alarms are disabled
  a_r11_min_wave: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_en && $past(!alarm_en)) |-> (aflag == ($past(cnt_sec) >= 8'h30)));

  // R12: a load lands on the next edge
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_load |=> (timer_val == $past(tmr_load_val)));
endmodule

bind atc_top atc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .acr(acr), .cnt_sec(cnt_sec),
  .tick_hund(tick_hund), .tick_sec(tick_sec), .tick_min(tick_min),
  .tick_hour(tick_hour), .tick_day(tick_day), .tmr_load(tmr_load),
  .tmr_load_val(tmr_load_val), .clr_tflag(clr_tflag), .tflag(tflag),
  .aflag(aflag), .timer_val(timer_val), .int_n(int_n)
);

// File: tb/atc_top_tb_top.sv
module atc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm_en = 1'b0;
  logic [7:0] acr = '0;
  logic [7:0] cnt_hund = '0, cnt_sec = '0, cnt_min = '0, cnt_hour = '0;
  logic [7:0] cnt_ydate = '0, cnt_wdmon = '0;
  logic [7:0] al_hund = '0, al_sec = '0, al_min = '0, al_hour = '0;
  logic [7:0] al_ydate = '0, al_wdmon = '0, al_timer = '0;
  logic       tick_hund = 0, tick_sec = 0, tick_min = 0, tick_hour = 0, tick_day = 0;
  logic       tmr_load = 0;
  logic [7:0] tmr_load_val = '0;
  logic       clr_tflag = 0, clr_aflag = 0;
  logic       tflag, aflag, int_n;
  logic [7:0] timer_val;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  atc_top dut_i (.*);

  // {wrap expected, load value, value after one seconds tick}
  localparam logic [16:0] VEC [0:7] = '{
    {1'b0, 8'h00, 8'h01}, {1'b0, 8'h08, 8'h09}, {1'b0, 8'h09, 8'h10},
    {1'b0, 8'h19, 8'h20}, {1'b0, 8'h49, 8'h50}, {1'b0, 8'h90, 8'h91},
    {1'b0, 8'h98, 8'h99}, {1'b1, 8'h99, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    tick_hund = 0; tick_sec = 0; tick_min = 0; tick_hour = 0; tick_day = 0;
    tmr_load = 0; clr_tflag = 0; clr_aflag = 0;
  endtask

  task automatic load(input logic [7:0] v);
    tmr_load = 1; tmr_load_val = v; cyc();
  endtask

  task automatic set_time(input logic [7:0] h);
    cnt_hund = h; cnt_sec = 8'h56; cnt_min = 8'h34; cnt_hour = 8'h12;
    cnt_ydate = 8'hD5; cnt_wdmon = 8'h67;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tflag", {7'd0, tflag}, 8'd0);
    chk("R1 aflag", {7'd0, aflag}, 8'd0);
    chk("R1 timer", timer_val, 8'h00);
    chk("R1 int_n", {7'd0, int_n}, 8'd1);
    rst_n = 1;
    cyc();
    alarm_en = 1; acr = 8'h02;
    cyc();

    // R2/R3/R12 vector table
    for (int i = 0; i < 8; i++) begin
      load(VEC[i][15:8]);
      chk("R12 load", timer_val, VEC[i][15:8]);
      tick_sec = 1; cyc();
      chk("R2 bcd step", timer_val, VEC[i][7:0]);
      chk("R3 wrap flag", {7'd0, tflag}, {7'd0, VEC[i][16]});
      clr_tflag = 1; cyc();
    end

    // R2: wrong unit and stopped timer
    load(8'h42);
    tick_min = 1; tick_hund = 1; cyc();
    chk("R2 other unit", timer_val, 8'h42);
    acr = 8'h00; tick_sec = 1; cyc();
    chk("R2 unit none", timer_val, 8'h42);
    acr = 8'h06; tick_day = 1; tick_sec = 1; cyc();
    chk("R2 unit 6", timer_val, 8'h42);
    acr = 8'h05; tick_day = 1; cyc();
    chk("R2 days", timer_val, 8'h43);

    // R12: load beats tick
    acr = 8'h02; tick_sec = 1; tmr_load = 1; tmr_load_val = 8'h77; cyc();
    chk("R12 load priority", timer_val, 8'h77);

    // R4: set and clear together, set wins
    load(8'h99);
    tick_sec = 1; clr_tflag = 1; cyc();
    chk("R4 set wins", {7'd0, tflag}, 8'd1);
    cyc(); cyc();
    chk("R4 sticky", {7'd0, tflag}, 8'd1);
    // R10 timer interrupt
    acr = 8'h0A; #1;
    chk("R10 timer irq", {7'd0, int_n}, 8'd0);
    acr = 8'h02; #1;
    chk("R10 irq masked", {7'd0, int_n}, 8'd1);
    clr_tflag = 1; cyc();
    chk("R4 clear", {7'd0, tflag}, 8'd0);

    // R5 dated alarm
    al_hund = 8'h78; al_sec = 8'h56; al_min = 8'h34; al_hour = 8'h12;
    al_ydate = 8'h15; al_wdmon = 8'h07;
    set_time(8'h77); acr = 8'h30; cyc();
    chk("R5 no match", {7'd0, aflag}, 8'd0);
    cnt_hund = 8'h78; cyc();
    chk("R5 dated hit", {7'd0, aflag}, 8'd1);
    // R8 clear while match persists
    clr_aflag = 1; cyc(); cyc();
    chk("R8 no refire", {7'd0, aflag}, 8'd0);
    cnt_hund = 8'h77; cyc(); cnt_hund = 8'h78; cyc();
    chk("R8 refire on new match", {7'd0, aflag}, 8'd1);
    clr_aflag = 1; cnt_hund = 8'h77; cyc();
    cnt_wdmon = 8'h68; cnt_hund = 8'h78; cyc();
    chk("R5 month mismatch", {7'd0, aflag}, 8'd0);

    // R6 daily
    cnt_hund = 8'h77; acr = 8'h10; cyc();
    cnt_hund = 8'h78; cyc();
    chk("R6 daily hit", {7'd0, aflag}, 8'd1);
    // R10 alarm interrupt
    acr = 8'h90; #1;
    chk("R10 alarm irq", {7'd0, int_n}, 8'd0);
    clr_aflag = 1; cnt_hund = 8'h77; cyc();

    // R7 weekday: weekday 3, mask without bit 3
    cnt_wdmon = 8'h67; al_wdmon = 8'h77; acr = 8'h20; cyc();
    cnt_hund = 8'h78; cyc();
    chk("R7 day masked", {7'd0, aflag}, 8'd0);
    cnt_hund = 8'h77; al_wdmon = 8'h08; cyc();
    cnt_hund = 8'h78; cyc();
    chk("R7 day enabled", {7'd0, aflag}, 8'd1);
    clr_aflag = 1; cnt_hund = 8'h77; cyc();

    // R9 timer alarm
    acr = 8'h42; al_timer = 8'h05; load(8'h04);
    chk("R9 before match", {7'd0, aflag}, 8'd0);
    tick_sec = 1; cyc();
    chk("R9 timer at value", timer_val, 8'h05);
    cyc();
    chk("R9 timer alarm", {7'd0, aflag}, 8'd1);
    clr_aflag = 1; cyc();

    // R11 square waves with alarms disabled
    alarm_en = 0; acr = 8'hFF; cnt_hund = 8'h60; cnt_sec = 8'h45; cyc();
    chk("R11 sec wave high", {7'd0, tflag}, 8'd1);
    chk("R11 min wave high", {7'd0, aflag}, 8'd1);
    chk("R11 int follows", {7'd0, int_n}, 8'd0);
    cnt_hund = 8'h49; cnt_sec = 8'h29; cyc();
    chk("R11 sec wave low", {7'd0, tflag}, 8'd0);
    chk("R11 min wave low", {7'd0, aflag}, 8'd0);
    chk("R11 acr ignored", {7'd0, int_n}, 8'd1);
    tick_sec = 1; tick_hund = 1; tick_day = 1; cyc();
    chk("R11 timer frozen", timer_val, 8'h05);

    finish_run();
  end
endmodule